// File: doc/BRIEF.md
# Remote Temperature Sensor Register Target

This block is the register file behind an emulated remote temperature sensor. A host issues single-byte register reads and writes over a simple parallel port, in the way an SMBus byte-data target would present them after the bus layer has decoded its address. A sensor feeds temperature samples into the block. The block keeps the live reading, a high and a low limit, a status byte, a configuration byte and a revision byte.

Every temperature is an 11-bit quantity in eighths of a degree, from 0.000 to 255.875. It is split over two byte registers: whole degrees, and a three-bit fraction. A host needs two accesses to read a reading. The block makes that pair atomic. The first access of the pair freezes the other half, and a strap-driven configuration bit selects which half comes first. The block also compares the live reading with both limits and raises alert flags.

Top module: `tsi_reg_target`

## Requirements
- R1: A host access is a one-cycle pulse of `hostSel`, with `hostWrite` choosing a write or a read. A write takes effect at that clock edge. Read data appears on `hostRdata` after the edge that accepts the read, and it holds until the next read.
- R2: An integer register holds whole degrees in plain binary. A fraction register carries eighths of a degree in bits 7:5, and bits 4:0 of it always read 0. Written bits 4:0 are discarded. `sampleTemp` is {integer[7:0], eighths[2:0]}.
- R3: The register addresses are:
  - 0x01: live integer
  - 0x10: live fraction
  - 0x02: status
  - 0x03: configuration
  - 0x07 and 0x13: high limit integer and fraction
  - 0x08 and 0x14: low limit integer and fraction
  - 0xFF: revision

  All four limit registers can be written and read back.
- R4: When the order bit is 0, a read of 0x01 returns the live integer and freezes the matching fraction. The next read of 0x10 returns the frozen fraction and releases it. Any read of 0x10 that follows returns the live value.
- R5: When the order bit is 1, a read of 0x10 returns the live fraction and freezes the matching integer. The next read of 0x01 returns the frozen integer and releases it.
- R6: A sample can arrive in the same cycle as a freezing read. In that case the read returns the value from before the sample, the frozen half also comes from before the sample, and the live value takes the new sample.
- R7: Status bit 4 is 1 exactly while live >= high limit, compared at full 11-bit resolution.
- R8: Status bit 3 is 1 exactly while live <= low limit. `alertOut` is the OR of status bits 4 and 3. The other status bits read 0.
- R9: Writes to 0x01, 0x10, 0x02, 0x03, 0xFF and to any unmapped address change nothing. A read of an unmapped address returns 0x00.
- R10: A read of 0xFF returns the revision parameter, which is 4 by default and never more than 4.
- R11: Configuration bit 5 is the order bit. It takes the value of `orderStrap` one cycle later, and every other configuration bit reads 0. Reset sets these values:
  - live reading: 0.000
  - high limit: 70.000 (0x46/0x00)
  - low limit: 0.000
  - order bit: 0
  - `hostRdata`: 0x00

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 8 | Register address |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Registered read data |
| sampleValid | input | 1 | New sensor sample present |
| sampleTemp | input | 11 | Sample, {integer, eighths} |
| orderStrap | input | 1 | Read-order strap |
| alertOut | output | 1 | High or low limit alert |

## Verification
Two events can land on the same clock edge: a host read that freezes one half of the reading, and the arrival of a new sensor sample. The bench drives both in one cycle, first with the order bit at 0 and then at 1. It then reads the second half to confirm that the pair still describes the old sample, and reads again to confirm that the live copy took the new one. A limit write that lands together with a sample is also exercised in random traffic. There the behavioural reference model judges the status byte and the alert on every cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam logic [7:0] ADR_TEMP_INT = 8'h01;
  localparam logic [7:0] ADR_STATUS   = 8'h02;
  localparam logic [7:0] ADR_CONFIG   = 8'h03;
  localparam logic [7:0] ADR_HI_INT   = 8'h07;
  localparam logic [7:0] ADR_LO_INT   = 8'h08;
  localparam logic [7:0] ADR_TEMP_FRC = 8'h10;
  localparam logic [7:0] ADR_HI_FRC   = 8'h13;
  localparam logic [7:0] ADR_LO_FRC   = 8'h14;
  localparam logic [7:0] ADR_REV      = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TINT, SEL_TFRC, SEL_STAT, SEL_CFG,
    SEL_HINT, SEL_HFRC, SEL_LINT, SEL_LFRC, SEL_REV
  } rdSel_e;

  typedef struct packed {
    logic   rdEn;
    rdSel_e rdSel;
    logic   wrHiInt;
    logic   wrHiFrc;
    logic   wrLoInt;
    logic   wrLoFrc;
  } strobe_t;

endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic       hostSel,
  input  logic       hostWrite,
  input  logic [7:0] hostAddr,
  output strobe_t    strb
);

  logic isRead;
  logic isWrite;

  assign isRead  = hostSel && !hostWrite;
  assign isWrite = hostSel && hostWrite;

  always_comb begin
    strb = '0;
    strb.rdEn = isRead;
    strb.rdSel = SEL_NONE;
    unique case (hostAddr)
      ADR_TEMP_INT: strb.rdSel = SEL_TINT;
      ADR_TEMP_FRC: strb.rdSel = SEL_TFRC;
      ADR_STATUS:   strb.rdSel = SEL_STAT;
      ADR_CONFIG:   strb.rdSel = SEL_CFG;
      ADR_HI_INT:   strb.rdSel = SEL_HINT;
      ADR_HI_FRC:   strb.rdSel = SEL_HFRC;
      ADR_LO_INT:   strb.rdSel = SEL_LINT;
      ADR_LO_FRC:   strb.rdSel = SEL_LFRC;
      ADR_REV:      strb.rdSel = SEL_REV;
      default:      strb.rdSel = SEL_NONE;
    endcase
    // only the four limit registers accept writes
    strb.wrHiInt = isWrite && (hostAddr == ADR_HI_INT);
    strb.wrHiFrc = isWrite && (hostAddr == ADR_HI_FRC);
    strb.wrLoInt = isWrite && (hostAddr == ADR_LO_INT);
    strb.wrLoFrc = isWrite && (hostAddr == ADR_LO_FRC);
  end

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FRAC_W     = 3,
  parameter int REV_ID     = 4,
  parameter int HI_RST_INT = 70
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [DATA_W-1:0]        hostWdata,
  input  logic                     sampleValid,
  input  logic [DATA_W+FRAC_W-1:0] sampleTemp,
  input  logic                     orderStrap,
  output logic [DATA_W-1:0]        hostRdata,
  output logic                     alertHigh,
  output logic                     alertLow
);

  localparam int PAD_W   = DATA_W - FRAC_W;
  localparam int ORD_BIT = 5;
  localparam int HI_BIT  = 4;
  localparam int LO_BIT  = 3;

  logic [DATA_W-1:0] liveInt, hiInt, loInt, shInt;
  logic [FRAC_W-1:0] liveFrc, hiFrc, loFrc, shFrc;
  logic              pendInt, pendFrc, orderBit;
  logic [DATA_W-1:0] rdQ, rdNext, statByte, cfgByte;

  function automatic logic [DATA_W-1:0] fracByte(input logic [FRAC_W-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction

  assign alertHigh = {liveInt, liveFrc} >= {hiInt, hiFrc};
  assign alertLow  = {liveInt, liveFrc} <= {loInt, loFrc};

  always_comb begin
    statByte = '0;
    statByte[HI_BIT] = alertHigh;
    statByte[LO_BIT] = alertLow;
    cfgByte = '0;
    cfgByte[ORD_BIT] = orderBit;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_TINT: rdNext = pendInt ? shInt : liveInt;
      SEL_TFRC: rdNext = fracByte(pendFrc ? shFrc : liveFrc);
      SEL_STAT: rdNext = statByte;
      SEL_CFG:  rdNext = cfgByte;
      SEL_HINT: rdNext = hiInt;
      SEL_HFRC: rdNext = fracByte(hiFrc);
      SEL_LINT: rdNext = loInt;
      SEL_LFRC: rdNext = fracByte(loFrc);
      SEL_REV:  rdNext = DATA_W'(REV_ID);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveInt  <= '0;
      liveFrc  <= '0;
      hiInt    <= DATA_W'(HI_RST_INT);
      hiFrc    <= '0;
      loInt    <= '0;
      loFrc    <= '0;
      shInt    <= '0;
      shFrc    <= '0;
      pendInt  <= 1'b0;
      pendFrc  <= 1'b0;
      orderBit <= 1'b0;
      rdQ      <= '0;
    end else begin
      if (sampleValid) begin
        liveInt <= sampleTemp[DATA_W+FRAC_W-1:FRAC_W];
        liveFrc <= sampleTemp[FRAC_W-1:0];
      end
      if (strb.wrHiInt) hiInt <= hostWdata;
      if (strb.wrHiFrc) hiFrc <= hostWdata[DATA_W-1:PAD_W];
      if (strb.wrLoInt) loInt <= hostWdata;
      if (strb.wrLoFrc) loFrc <= hostWdata[DATA_W-1:PAD_W];
      orderBit <= orderStrap;
      if (strb.rdEn) rdQ <= rdNext;
      // freezing reads capture the partner half from before any new sample
      if (strb.rdEn && strb.rdSel == SEL_TINT) begin
        pendInt <= 1'b0;
        if (!orderBit) begin
          shFrc   <= liveFrc;
          pendFrc <= 1'b1;
        end
      end
      if (strb.rdEn && strb.rdSel == SEL_TFRC) begin
        pendFrc <= 1'b0;
        if (orderBit) begin
          shInt   <= liveInt;
          pendInt <= 1'b1;
        end
      end
    end
  end

  assign hostRdata = rdQ;

endmodule

// File: rtl/tsi_reg_target.sv
module tsi_reg_target
  import tsi_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FRAC_W     = 3,
  parameter int REV_ID     = 4,
  parameter int HI_RST_INT = 70
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostSel,
  input  logic                     hostWrite,
  input  logic [7:0]               hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  output logic [DATA_W-1:0]        hostRdata,
  input  logic                     sampleValid,
  input  logic [DATA_W+FRAC_W-1:0] sampleTemp,
  input  logic                     orderStrap,
  output logic                     alertOut
);

  strobe_t strb;
  logic    alertHigh;
  logic    alertLow;

  tsi_ctrl u_ctrl (
    .hostSel   (hostSel),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .strb      (strb)
  );

  tsi_datapath #(
    .DATA_W     (DATA_W),
    .FRAC_W     (FRAC_W),
    .REV_ID     (REV_ID),
    .HI_RST_INT (HI_RST_INT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .hostWdata   (hostWdata),
    .sampleValid (sampleValid),
    .sampleTemp  (sampleTemp),
    .orderStrap  (orderStrap),
    .hostRdata   (hostRdata),
    .alertHigh   (alertHigh),
    .alertLow    (alertLow)
  );

  assign alertOut = alertHigh | alertLow;

endmodule

// File: rtl/tsi_reg_target_chk.sv
module tsi_reg_target_chk #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 3,
  parameter int REV_ID = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostSel,
  input logic              hostWrite,
  input logic [7:0]        hostAddr,
  input logic [DATA_W-1:0] hostRdata,
  input logic              alertOut,
  input logic              alertHigh,
  input logic              alertLow
);

  localparam int PAD_W = DATA_W - FRAC_W;

  logic rdAcc, fracRd, unmappedRd, statRd;

  assign rdAcc      = hostSel && !hostWrite;
  assign fracRd     = rdAcc && (hostAddr == 8'h10 || hostAddr == 8'h13 || hostAddr == 8'h14);
  assign statRd     = rdAcc && (hostAddr == 8'h02);
  assign unmappedRd = rdAcc && !(hostAddr inside {8'h01, 8'h02, 8'h03, 8'h07, 8'h08,
                                                  8'h10, 8'h13, 8'h14, 8'hFF});

  // R1: read data holds between reads
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdAcc |=> $stable(hostRdata));

  // R2: pad bits of any fraction read are zero
  a_r2_frac_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    fracRd |=> (hostRdata[PAD_W-1:0] == '0));

  // R7: status bit 4 reflects the high comparison
  a_r7_status_high: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> (hostRdata[4] == $past(alertHigh)) && (hostRdata[3] == $past(alertLow)));

  // R8: the alert pin agrees with the status byte
  a_r8_alert_matches_status: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> ((|hostRdata) == $past(alertOut)));

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    unmappedRd |=> (hostRdata == '0));

  // R10: revision read returns the identifier, at most 4
  a_r10_revision: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && hostAddr == 8'hFF) |=> (hostRdata == DATA_W'(REV_ID)) && (hostRdata <= DATA_W'(4)));

endmodule

bind tsi_reg_target tsi_reg_target_chk #(
  .DATA_W (DATA_W),
  .FRAC_W (FRAC_W),
  .REV_ID (REV_ID)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostSel   (hostSel),
  .hostWrite (hostWrite),
  .hostAddr  (hostAddr),
  .hostRdata (hostRdata),
  .alertOut  (alertOut),
  .alertHigh (alertHigh),
  .alertLow  (alertLow)
);

// File: tb/tsi_reg_target_tb.sv
module tsi_reg_target_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWrite = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        sampleValid = 1'b0;
  logic [10:0] sampleTemp = '0;
  logic        orderStrap = 1'b0;
  logic        alertOut;

  int totalCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;
  bit running = 1'b0;
  string curReq = "R11";

  // behavioural reference, temperatures in eighths of a degree
  int mLive, mHi, mLo, mShInt, mShFrc, mOrd, mRd;
  bit mPi, mPf;

  always #5 clk = ~clk;

  tsi_reg_target u_dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .orderStrap(orderStrap), .alertOut(alertOut)
  );

  function int mStatus();
    return ((mLive >= mHi) ? 16 : 0) + ((mLive <= mLo) ? 8 : 0);
  endfunction

  function int mRead(input int a);
    case (a)
      8'h01: return mPi ? mShInt : (mLive >> 3);
      8'h10: return (mPf ? mShFrc : (mLive % 8)) << 5;
      8'h02: return mStatus();
      8'h03: return mOrd ? 32 : 0;
      8'h07: return mHi >> 3;
      8'h13: return (mHi % 8) << 5;
      8'h08: return mLo >> 3;
      8'h14: return (mLo % 8) << 5;
      8'hFF: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLive = 0; mHi = 70 * 8; mLo = 0; mShInt = 0; mShFrc = 0;
      mPi = 0; mPf = 0; mOrd = 0; mRd = 0;
    end else begin
      if (hostSel && !hostWrite) begin
        mRd = mRead(hostAddr);
        if (hostAddr == 8'h01) begin
          mPi = 0;
          if (mOrd == 0) begin mShFrc = mLive % 8; mPf = 1; end
        end
        if (hostAddr == 8'h10) begin
          mPf = 0;
          if (mOrd == 1) begin mShInt = mLive >> 3; mPi = 1; end
        end
      end else if (hostSel && hostWrite) begin
        case (hostAddr)
          8'h07: mHi = hostWdata * 8 + mHi % 8;
          8'h13: mHi = (mHi / 8) * 8 + (hostWdata >> 5);
          8'h08: mLo = hostWdata * 8 + mLo % 8;
          8'h14: mLo = (mLo / 8) * 8 + (hostWdata >> 5);
          default: ;
        endcase
      end
      if (sampleValid) mLive = sampleTemp;
      mOrd = orderStrap;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    totalCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (running) begin
      check(curReq, hostRdata, mRd, "rdata vs model");
      check(curReq, alertOut, (mStatus() != 0) ? 1 : 0, "alert vs model");
    end
  end

  // one access cycle, starting and ending on a falling edge
  task automatic op(input bit s, input bit w, input logic [7:0] a, input logic [7:0] d,
                    input bit sv, input logic [10:0] st);
    hostSel = s; hostWrite = w; hostAddr = a; hostWdata = d;
    sampleValid = sv; sampleTemp = st;
    @(negedge clk);
    hostSel = 1'b0; hostWrite = 1'b0; sampleValid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    op(1, 0, a, 8'h00, 0, '0);
    check(req, hostRdata, exp, $sformatf("read 0x%02h", a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(1, 1, a, d, 0, '0);
  endtask

  task automatic smp(input logic [10:0] t);
    op(0, 0, 8'h00, 8'h00, 1, t);
  endtask

  task automatic idle();
    op(0, 0, 8'h00, 8'h00, 0, '0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    logic [7:0] addrs [12] = '{8'h01, 8'h10, 8'h02, 8'h03, 8'h07, 8'h08,
                               8'h13, 8'h14, 8'hFF, 8'h40, 8'h11, 8'h00};
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", hostRdata, 0, "rdata in reset");
    check("R11", alertOut, 1, "alert in reset (0 <= low 0)");
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;
    rd(8'h07, 8'h46, "R11");
    rd(8'h13, 8'h00, "R11");
    rd(8'h08, 8'h00, "R11");
    rd(8'h03, 8'h00, "R11");
    rd(8'h02, 8'h08, "R8");
    rd(8'hFF, 8'h04, "R10");

    // R2 encoding: 25.125 = 0x19 / 0x20
    curReq = "R2";
    smp(11'd201);
    rd(8'h01, 8'h19, "R2");
    rd(8'h10, 8'h20, "R2");
    rd(8'h02, 8'h00, "R7");

    // R4 and R6: order 0, sample lands with the freezing read
    curReq = "R6";
    op(1, 0, 8'h01, 8'h00, 1, 11'd212);
    check("R6", hostRdata, 8'h19, "integer read with sample");
    rd(8'h10, 8'h20, "R4");
    rd(8'h10, 8'h80, "R4");

    // R5 and R6: order 1
    curReq = "R5";
    orderStrap = 1'b1;
    idle();
    rd(8'h03, 8'h20, "R11");
    rd(8'h10, 8'h80, "R5");
    smp(11'd240);
    rd(8'h01, 8'h1A, "R5");
    rd(8'h01, 8'h1E, "R5");
    curReq = "R6";
    op(1, 0, 8'h10, 8'h00, 1, 11'd250);
    check("R6", hostRdata, 8'h00, "fraction read with sample");
    rd(8'h01, 8'h1E, "R6");
    rd(8'h01, 8'h1F, "R6");
    orderStrap = 1'b0;
    idle();

    // R3 and R7: high limit 32.875
    curReq = "R7";
    wr(8'h07, 8'h20);
    wr(8'h13, 8'hFF);
    rd(8'h07, 8'h20, "R3");
    rd(8'h13, 8'hE0, "R3");
    smp(11'd263);
    rd(8'h02, 8'h10, "R7");
    check("R7", alertOut, 1, "alert at high limit");
    smp(11'd262);
    rd(8'h02, 8'h00, "R7");

    // R8: low limit 20.000
    curReq = "R8";
    wr(8'h08, 8'h14);
    rd(8'h08, 8'h14, "R3");
    smp(11'd160);
    rd(8'h02, 8'h08, "R8");
    check("R8", alertOut, 1, "alert at low limit");

    // R9: ignored writes, unmapped reads
    curReq = "R9";
    wr(8'h01, 8'h55);
    wr(8'h02, 8'hFF);
    wr(8'h03, 8'hFF);
    wr(8'hFF, 8'h00);
    wr(8'h40, 8'h77);
    rd(8'h01, 8'h14, "R9");
    rd(8'h02, 8'h08, "R9");
    rd(8'h03, 8'h00, "R9");
    rd(8'hFF, 8'h04, "R9");
    rd(8'h40, 8'h00, "R9");
    rd(8'h07, 8'h20, "R9");

    // R2: low bits of a fraction write discarded
    curReq = "R2";
    wr(8'h13, 8'h3F);
    rd(8'h13, 8'h20, "R2");

    // R7: full-scale and zero boundaries
    curReq = "R7";
    smp(11'h7FF);
    rd(8'h01, 8'hFF, "R7");
    rd(8'h10, 8'hE0, "R7");
    rd(8'h02, 8'h10, "R7");
    smp(11'd0);
    rd(8'h02, 8'h08, "R8");

    // R1: random traffic against the model
    curReq = "R1";
    for (int i = 0; i < 400; i++) begin
      int kind = $urandom_range(0, 3);
      if ($urandom_range(0, 15) == 0) orderStrap = ~orderStrap;
      if (kind == 0)
        op(1, 1, addrs[$urandom_range(0, 11)], 8'($urandom), $urandom_range(0, 1), 11'($urandom));
      else
        op(1, 0, addrs[$urandom_range(0, 11)], 8'h00, $urandom_range(0, 1), 11'($urandom));
    end
    idle();
    running = 1'b0;
    done = 1'b1;
    finishRun();
  end

endmodule